// File: doc/BRIEF.md
# Dual-Rail Power Sequencing Supervisor

This block is the digital sequencer for a pair of switching regulators. It watches an enable line, two supply-monitor flags, a die temperature code and one "output in regulation" flag per rail. From these it decides when each rail may switch. It runs a soft-start ramp counter for each rail and drives reset low whenever the outputs are not yet good.

After enable, rail 0 ramps up first. Rail 1 ramps up only after rail 0's ramp has completed. When enable drops, the rails ramp down in the opposite order. A supply brown-out sets a lockout latch. Once set, the latch clears only after the supply has fallen below a lower re-arm level. An over-temperature trip stops both rails, clears both ramps and holds them off until the die has cooled past a hysteresis band. The analog comparators, the PWM loop and the gate drivers sit outside this block.

Top module: `rail_seq_supervisor`

## Requirements
- R1: While `uvlo_i` is high (after two synchronizer flops), `gate_hi_o`, `gate_lo_o` and `rst_no` are all low and the state goes to OFF.
- R2: The lockout set by `uvlo_i` holds the block in OFF after `uvlo_i` falls again. It clears only once `rearm_i` has been seen high.
- R3: `state_o` uses this encoding: OFF=0, RAMP0=1, RAMP1=2, ON=3, STOP1=4, STOP0=5. With no fault present, `en_i` high brings the block to ON and `en_i` low brings it back to OFF. Out of reset `state_o` is 0 and all outputs are low.
- R4: After enable, only rail 0 (bit 0 of the gate outputs) runs at first. Rail 1 (bit 1) starts only after rail 0's ramp is complete.
- R5: `rst_no` goes high only when the state is ON, both ramps are complete and both `pgood_i` bits are high.
- R6: `rst_no` goes low whenever either `pgood_i` bit is low, while the rails keep running.
- R7: With `en_i` low, rail 1 ramps down first while rail 0 keeps running. Rail 0 ramps down only after rail 1's counter has reached zero.
- R8: A `temp_i` value above TEMP_TRIP (160) forces the state to OFF, drives the gate outputs and `rst_no` low, and clears both ramp counters. Operation resumes only once `temp_i` is at or below TEMP_TRIP minus TEMP_HYST (150).
- R9: Each ramp counter is RAMP_W bits wide. It steps once every TICK_DIV clocks, saturates at all-ones (ramp complete) and counts down to zero without wrapping.
- R10: A change of `en_i` during a ramp reverses the ramp direction starting from the current count, with no reload.
- R11: `ramp_done_o[i]` is high exactly when rail i's counter is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable for both rails (asynchronous) |
| uvlo_i | input | 1 | Supply below lockout level (asynchronous) |
| rearm_i | input | 1 | Supply below re-arm level (asynchronous) |
| temp_i | input | TEMP_W | Die temperature code in degrees |
| pgood_i | input | 2 | Per-rail output above 90 % of nominal (asynchronous) |
| gate_hi_o | output | 2 | Per-rail high-side drive enable |
| gate_lo_o | output | 2 | Per-rail low-side drive enable |
| rst_no | output | 1 | Reset indication, active low |
| state_o | output | 3 | Sequencer state encoding |
| ramp_done_o | output | 2 | Per-rail ramp-complete flags |

## Verification
Two events can land on the same clock edge: a ramp reaching its limit and a reversal of enable or a fault. The bench therefore reverses enable during the rail 0 soft-stop. It then checks that the ramp back up to RAMP1 takes far fewer cycles than a full ramp, which shows the count was carried over and not reset. Thermal and lockout faults are raised while both rails are ON and ramping has settled, and are judged by the state, gate and reset outputs. The thermal band edges at 155 (still off) and 150 (resume) are also exercised.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP0 = 3'd1,
    ST_RAMP1 = 3'd2,
    ST_ON    = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP0 = 3'd5
  } seq_state_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ramp_ctr.sv
module ramp_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && up_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (tick_i && dn_i && !empty_o) cnt_q <= cnt_q - 1'b1;
  end
  assign cnt_o   = cnt_q;
  assign full_o  = &cnt_q;
  assign empty_o = ~|cnt_q;

  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && tick_i && up_i && !clr_i) |=> full_o); // R9
  AST_SAT_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && tick_i && dn_i) |=> empty_o); // R9
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R8
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TW   = 8,
  parameter int TRIP = 160,
  parameter int HYST = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] temp_i,
  output logic          hot_o
);
  localparam logic [TW-1:0] TRIP_C   = TW'(TRIP);
  localparam logic [TW-1:0] RESUME_C = TW'(TRIP - HYST);
  logic hot_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hot_q <= 1'b0;
    else if (temp_i > TRIP_C)     hot_q <= 1'b1;
    else if (temp_i <= RESUME_C)  hot_q <= 1'b0;
  end
  assign hot_o = hot_q;

  AST_HOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_o && temp_i > RESUME_C) |=> hot_o); // R8
  AST_COOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_o && temp_i <= TRIP_C) |=> !hot_o); // R8
endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor
  import rail_seq_pkg::*;
#(
  parameter int RAMP_W    = 4,
  parameter int TICK_DIV  = 4,
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 160,
  parameter int TEMP_HYST = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              uvlo_i,
  input  logic              rearm_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [1:0]        pgood_i,
  output logic [1:0]        gate_hi_o,
  output logic [1:0]        gate_lo_o,
  output logic              rst_no,
  output logic [2:0]        state_o,
  output logic [1:0]        ramp_done_o
);
  localparam int NRAIL = 2;
  localparam int NSYNC = 3 + NRAIL;

  logic [NSYNC-1:0] sync_d, sync_q;
  logic en_s, uvlo_s, rearm_s;
  logic [NRAIL-1:0] pgood_s;

  assign sync_d = {pgood_i, rearm_i, uvlo_i, en_i};
  flag_sync #(.W(NSYNC)) u_sync (.clk_i, .rst_ni, .d_i(sync_d), .q_o(sync_q));
  assign {pgood_s, rearm_s, uvlo_s, en_s} = sync_q;

  // lockout latch: re-arm has priority, uvlo still blocks while present
  logic lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (rearm_s) lock_q <= 1'b0;
    else if (uvlo_s)  lock_q <= 1'b1;
  end

  logic hot;
  thermal_guard #(.TW(TEMP_W), .TRIP(TEMP_TRIP), .HYST(TEMP_HYST)) u_therm (
    .clk_i, .rst_ni, .temp_i, .hot_o(hot));

  logic fault;
  assign fault = lock_q | uvlo_s | hot;

  logic tick;
  tick_gen #(.DIV(TICK_DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  seq_state_e state_q, state_d;
  logic [NRAIL-1:0] ramp_up, ramp_dn, ramp_full, ramp_empty;
  logic [RAMP_W-1:0] ramp_cnt [NRAIL];

  always_comb begin
    ramp_up = '0;
    ramp_dn = '0;
    unique case (state_q)
      ST_RAMP0: ramp_up[0] = 1'b1;
      ST_RAMP1: ramp_up[1] = 1'b1;
      ST_STOP1: ramp_dn[1] = 1'b1;
      ST_STOP0: ramp_dn[0] = 1'b1;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    ramp_ctr #(.W(RAMP_W)) u_ramp (
      .clk_i, .rst_ni, .clr_i(fault), .tick_i(tick),
      .up_i(ramp_up[i]), .dn_i(ramp_dn[i]),
      .cnt_o(ramp_cnt[i]), .full_o(ramp_full[i]), .empty_o(ramp_empty[i]));
  end

  always_comb begin
    state_d = state_q;
    if (fault) state_d = ST_OFF;
    else begin
      unique case (state_q)
        ST_OFF:   if (en_s) state_d = ST_RAMP0;
        ST_RAMP0: if (!en_s) state_d = ST_STOP0;
                  else if (ramp_full[0]) state_d = ST_RAMP1;
        ST_RAMP1: if (!en_s) state_d = ST_STOP1;
                  else if (ramp_full[1]) state_d = ST_ON;
        ST_ON:    if (!en_s) state_d = ST_STOP1;
        ST_STOP1: if (en_s) state_d = ST_RAMP1;
                  else if (ramp_empty[1]) state_d = ST_STOP0;
        ST_STOP0: if (en_s) state_d = ST_RAMP0;
                  else if (ramp_empty[0]) state_d = ST_OFF;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  logic [NRAIL-1:0] run;
  assign run[0] = !fault && (state_q != ST_OFF);
  assign run[1] = !fault && (state_q inside {ST_RAMP1, ST_ON, ST_STOP1});

  assign gate_hi_o   = run;
  assign gate_lo_o   = run;
  assign rst_no      = !fault && (state_q == ST_ON) && (&ramp_full) && (&pgood_s);
  assign state_o     = state_q;
  assign ramp_done_o = ramp_full;

  AST_RAIL1_AFTER_RAIL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP1) |-> ramp_full[0]); // R4
  AST_STOP_REVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP0) |-> ramp_empty[1]); // R7
  AST_RST_NEEDS_RAMPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no |-> (&ramp_done_o)); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !rearm_s) |=> lock_q); // R2
  AST_FAULT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (state_q == ST_OFF)); // R1
endmodule

// File: tb/sim_rail_seq_supervisor.sv
module sim_rail_seq_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, uvlo = 1'b0, rearm = 1'b0;
  logic [7:0] temp = 8'd25;
  logic [1:0] pgood = 2'b11;
  logic [1:0] ghi, glo, done;
  logic rstn_o;
  logic [2:0] st;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rail_seq_supervisor u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_i(uvlo), .rearm_i(rearm),
    .temp_i(temp), .pgood_i(pgood), .gate_hi_o(ghi), .gate_lo_o(glo),
    .rst_no(rstn_o), .state_o(st), .ramp_done_o(done));

  // {en, uvlo, rearm, temp[8], pgood[2], exp_state[3], exp_run[2], exp_rst}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'd25,  2'b11, 3'd3, 2'b11, 1'b1},  // R3 R5 on
    {1'b1, 1'b0, 1'b0, 8'd25,  2'b01, 3'd3, 2'b11, 1'b0},  // R6 rail1 low
    {1'b1, 1'b0, 1'b0, 8'd25,  2'b11, 3'd3, 2'b11, 1'b1},  // R5 recovered
    {1'b1, 1'b0, 1'b0, 8'd170, 2'b11, 3'd0, 2'b00, 1'b0},  // R8 trip
    {1'b1, 1'b0, 1'b0, 8'd155, 2'b11, 3'd0, 2'b00, 1'b0},  // R8 in band
    {1'b1, 1'b0, 1'b0, 8'd150, 2'b11, 3'd3, 2'b11, 1'b1},  // R8 resume
    {1'b1, 1'b1, 1'b0, 8'd25,  2'b11, 3'd0, 2'b00, 1'b0},  // R1 lockout
    {1'b1, 1'b0, 1'b0, 8'd25,  2'b11, 3'd0, 2'b00, 1'b0},  // R2 latched
    {1'b1, 1'b1, 1'b1, 8'd25,  2'b11, 3'd0, 2'b00, 1'b0},  // R2 re-arm
    {1'b1, 1'b0, 1'b0, 8'd25,  2'b11, 3'd3, 2'b11, 1'b1},  // R2 restart
    {1'b0, 1'b0, 1'b0, 8'd25,  2'b11, 3'd0, 2'b00, 1'b0}   // R7 R3 off
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [2:0] target, input int limit, output int n);
    n = 0;
    while (st != target && n < limit) begin
      @(negedge clk);
      n++;
    end
    check("R3 state reached", int'(st), int'(target));
  endtask

  initial begin
    cyc(100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    check("R3 reset state", int'(st), 0);
    check("R3 reset gates", int'({ghi, glo}), 0);
    check("R3 reset rst_no", int'(rstn_o), 0);
    check("R11 reset done", int'(done), 0);
    rst_n = 1'b1;
    cyc(20);
    check("R3 stays off", int'(st), 0);

    en = 1'b1;
    cyc(10);
    check("R4 ramp0 state", int'(st), 1);
    check("R4 only rail0", int'(ghi), 1);
    wait_state(3'd2, 200, n);
    check("R4 rail0 done first", int'(done), 1);
    check("R4 both run", int'(glo), 3);
    check("R5 no rst during ramp", int'(rstn_o), 0);
    wait_state(3'd3, 200, n);
    cyc(2);
    check("R5 rst released", int'(rstn_o), 1);
    check("R11 both done", int'(done), 3);

    en = 1'b0;
    cyc(10);
    check("R7 rail1 stops first", int'(st), 4);
    check("R7 rail0 still runs", int'(ghi), 3);
    wait_state(3'd5, 200, n);
    check("R7 rail1 off", int'(ghi), 1);
    check("R9 rail1 drained", int'(done), 1);

    cyc(8);
    en = 1'b1;
    cyc(6);
    check("R10 reversed to ramp0", int'(st), 1);
    check("R10 rail0 kept", int'(ghi), 1);
    wait_state(3'd2, 200, n);
    check("R10 short reramp", int'(n < 40), 1);
    wait_state(3'd3, 200, n);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      {en, uvlo, rearm, temp, pgood} = v[18:6];
      cyc(300);
      check($sformatf("R3 vec%0d state", i), int'(st), int'(v[5:3]));
      check($sformatf("R1 R8 vec%0d gates", i), int'(ghi), int'(v[2:1]));
      check($sformatf("R1 R8 vec%0d low gates", i), int'(glo), int'(v[2:1]));
      check($sformatf("R5 R6 vec%0d rst_no", i), int'(rstn_o), int'(v[0]));
      check($sformatf("R9 R11 vec%0d done", i), int'(done),
            (v[5:3] == 3'd3) ? 3 : 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule